// File: doc/BRIEF.md
# Breakpoint Comparison Unit

This block sits beside a processor core and watches its instruction stream and data-memory traffic. Every cycle it compares the program counter of a retiring instruction, and any data-memory read or write address, against a small set of programmed comparators. When a programmed condition holds, it raises a single-cycle break request one clock later. Halting the core, and the link that programs the unit, belong to other blocks.

There are two dedicated program-address comparators and a pair of combined comparators. A mode code sets how the combined pair behaves:
- both match program addresses;
- one matches program addresses and the other data addresses;
- both match data addresses;
- the pair merges into one value/mask range match on either program or data addresses.

Two more sources need no address: a break on every retired instruction that changes program flow, and a single-step break on every retired instruction. A sticky status vector records which sources have fired. Software clears it by writing ones.

Top module: `brk_unit`

## Requirements
- R1: After reset `brk_o` is 0 and `brk_src_o` is all zero. All comparator registers and the control register reset to zero, so every source is off.
- R2: Dedicated comparator k (register k, k = 0 or 1) matches when `retire_i` is high, its enable bit (wdata bit 17) is set, and `pc_i` equals its 17-bit value (wdata bits 16:0). It sets `brk_src_o[k]`. `brk_o` pulses in the cycle after the qualifying event, and `brk_src_o` is updated at the same edge.
- R3: Combined registers are at addresses 2 and 3, with the same layout as the dedicated ones. Control is at address 4: mode in bits 2:0, qualifier of slot 0 in 4:3, qualifier of slot 1 in 6:5, flow-break enable in bit 7, single-step enable in bit 8. Mode 0 makes both slots program matches. Mode 1 makes slot 0 a program match and slot 1 a data match. Mode 2 makes both slots data matches. Slot 0 reports on bit 2 and slot 1 on bit 3.
- R4: In mode 3, `pc_i` on a retired instruction matches when (pc AND M) equals (V AND M). V is the value in register 2, M is the value in register 3, and register 2's enable gates the match. The match reports on bit 2, and bit 3 never fires.
- R5: In mode 4, the same masked comparison uses the lower 16 bits against `daddr_i` on a data access allowed by slot 0's qualifier. It reports on bit 2.
- R6: Mode codes 5, 6 and 7 disable both combined slots. The dedicated comparators and the flow and step sources stay active in every mode.
- R7: The data qualifier codes are: 0 never matches, 1 reads only (`drd_i`), 2 writes only (`dwr_i`), 3 either. A data slot compares `daddr_i` with the lower 16 bits of its register.
- R8: A comparator whose enable bit is clear never matches.
- R9: With flow-break enabled, a retired instruction with `flow_chg_i` high sets bit 4 and pulses `brk_o`.
- R10: With single-step enabled, every retired instruction sets bit 5 and pulses `brk_o`.
- R11: `brk_o` is high only in the cycle after a qualifying event. Status bits stay set until a write to address 5 with a one in that bit position. A source firing in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 17 | Word address of the instruction now retiring |
| retire_i | input | 1 | Instruction-retired strobe |
| flow_chg_i | input | 1 | Retiring instruction changed program flow |
| daddr_i | input | 16 | Data-memory access address |
| drd_i | input | 1 | Data read strobe |
| dwr_i | input | 1 | Data write strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 18 | Configuration write data |
| brk_o | output | 1 | Break request pulse |
| brk_src_o | output | 6 | Sticky break-source status |

## Verification
The assertions assume that configuration writes only land on addresses 0 to 5, and that `flow_chg_i` means something only while `retire_i` is high. The bench drives flow changes only together with a retirement, except for one vector that checks the lone flag is ignored. The sticky-status property also assumes that reset has been released through the internal synchronizer before any event arrives. The bench holds every strobe low until several cycles after reset release. It writes only the defined addresses and applies each event for a single cycle followed by an idle cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [2:0] {
    MD_PP   = 3'd0,
    MD_PD   = 3'd1,
    MD_DD   = 3'd2,
    MD_PRNG = 3'd3,
    MD_DRNG = 3'd4
  } mode_t;

  typedef enum logic [1:0] {
    Q_NONE = 2'd0,
    Q_RD   = 2'd1,
    Q_WR   = 2'd2,
    Q_ANY  = 2'd3
  } qual_t;

  // control register layout, low bits first: mode, qual0, qual1, flow, step
  typedef struct packed {
    logic  step_en;
    logic  flow_en;
    qual_t q1;
    qual_t q0;
    mode_t mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/brk_cfg.sv
module brk_cfg
  import brk_pkg::*;
#(
  parameter int PC_W = 17,
  parameter int NFIX = 2,
  parameter int AW   = 3
) (
  input  logic                       clk,
  input  logic                       rst_q,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [PC_W:0]              wdata,
  output logic [NFIX-1:0][PC_W-1:0]  fix_val,
  output logic [NFIX-1:0]            fix_en,
  output logic [1:0][PC_W-1:0]       cmb_val,
  output logic [1:0]                 cmb_en,
  output ctrl_t                      ctrl
);

  localparam int CMB_BASE  = NFIX;
  localparam int CTRL_ADDR = NFIX + 2;

  for (genvar i = 0; i < NFIX; i++) begin : g_fix
    logic [PC_W:0] r_q, r_d;
    always_comb begin
      r_d = r_q;
      if (we && addr == AW'(i)) r_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) r_q <= '0;
      else        r_q <= r_d;
    end
    assign fix_val[i] = r_q[PC_W-1:0];
    assign fix_en[i]  = r_q[PC_W];
  end

  for (genvar k = 0; k < 2; k++) begin : g_cmb
    logic [PC_W:0] r_q, r_d;
    always_comb begin
      r_d = r_q;
      if (we && addr == AW'(CMB_BASE + k)) r_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) r_q <= '0;
      else        r_q <= r_d;
    end
    assign cmb_val[k] = r_q[PC_W-1:0];
    assign cmb_en[k]  = r_q[PC_W];
  end

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we && addr == AW'(CTRL_ADDR)) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] v,
  input  logic [W-1:0] m,
  input  logic         en,
  input  logic         stb,
  output logic         hit
);

  logic [W-1:0] diff;

  always_comb begin
    diff = (a ^ v) & m;
    hit  = en && stb && (diff == '0);
  end

endmodule

// File: rtl/brk_route.sv
module brk_route
  import brk_pkg::*;
#(
  parameter int PC_W = 17,
  parameter int DA_W = 16
) (
  input  ctrl_t                 ctrl,
  input  logic [1:0][PC_W-1:0]  cmb_val,
  input  logic [1:0]            cmb_en,
  input  logic [PC_W-1:0]       pc,
  input  logic                  retire,
  input  logic [DA_W-1:0]       daddr,
  input  logic                  drd,
  input  logic                  dwr,
  output logic [1:0]            cmb_hit
);

  localparam logic [PC_W-1:0] DMASK = PC_W'({DA_W{1'b1}});

  logic [1:0]            sel_data;
  logic [1:0]            slot_on;
  logic [1:0][PC_W-1:0]  mask;
  logic [1:0]            dstb;
  logic [PC_W-1:0]       daddr_x;

  assign daddr_x = PC_W'(daddr);

  always_comb begin
    dstb[0] = (drd && ctrl.q0[0]) || (dwr && ctrl.q0[1]);
    dstb[1] = (drd && ctrl.q1[0]) || (dwr && ctrl.q1[1]);
  end

  always_comb begin
    sel_data = '0;
    slot_on  = '0;
    mask[0]  = '1;
    mask[1]  = '1;
    case (ctrl.mode)
      MD_PP: begin
        slot_on = cmb_en;
      end
      MD_PD: begin
        slot_on     = cmb_en;
        sel_data[1] = 1'b1;
        mask[1]     = DMASK;
      end
      MD_DD: begin
        slot_on  = cmb_en;
        sel_data = 2'b11;
        mask[0]  = DMASK;
        mask[1]  = DMASK;
      end
      MD_PRNG: begin
        slot_on[0] = cmb_en[0];
        mask[0]    = cmb_val[1];
      end
      MD_DRNG: begin
        slot_on[0]  = cmb_en[0];
        sel_data[0] = 1'b1;
        mask[0]     = cmb_val[1] & DMASK;
      end
      default: begin
        slot_on = '0;
      end
    endcase
  end

  for (genvar k = 0; k < 2; k++) begin : g_slot
    logic [PC_W-1:0] a_sel;
    logic            s_sel;
    always_comb begin
      a_sel = sel_data[k] ? daddr_x : pc;
      s_sel = sel_data[k] ? dstb[k] : retire;
    end
    brk_cmp #(.W(PC_W)) u_cmp (
      .a   (a_sel),
      .v   (cmb_val[k]),
      .m   (mask[k]),
      .en  (slot_on[k]),
      .stb (s_sel),
      .hit (cmb_hit[k])
    );
  end

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int PC_W = 17,
  parameter int DA_W = 16,
  parameter int NFIX = 2,
  parameter int AW   = $clog2(NFIX + 4),
  parameter int NSRC = NFIX + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             retire_i,
  input  logic             flow_chg_i,
  input  logic [DA_W-1:0]  daddr_i,
  input  logic             drd_i,
  input  logic             dwr_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [PC_W:0]    cfg_wdata_i,
  output logic             brk_o,
  output logic [NSRC-1:0]  brk_src_o
);

  localparam int CLR_ADDR = NFIX + 3;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [NFIX-1:0][PC_W-1:0] fix_val;
  logic [NFIX-1:0]           fix_en;
  logic [1:0][PC_W-1:0]      cmb_val;
  logic [1:0]                cmb_en;
  ctrl_t                     ctrl;
  logic                      step_en;
  logic                      flow_en;

  brk_cfg #(.PC_W(PC_W), .NFIX(NFIX), .AW(AW)) u_cfg (
    .clk     (clk),
    .rst_q   (rst_q),
    .we      (cfg_we_i),
    .addr    (cfg_addr_i),
    .wdata   (cfg_wdata_i),
    .fix_val (fix_val),
    .fix_en  (fix_en),
    .cmb_val (cmb_val),
    .cmb_en  (cmb_en),
    .ctrl    (ctrl)
  );

  assign step_en = ctrl.step_en;
  assign flow_en = ctrl.flow_en;

  logic [NFIX-1:0] fix_hit;

  for (genvar i = 0; i < NFIX; i++) begin : g_fixcmp
    brk_cmp #(.W(PC_W)) u_cmp (
      .a   (pc_i),
      .v   (fix_val[i]),
      .m   ({PC_W{1'b1}}),
      .en  (fix_en[i]),
      .stb (retire_i),
      .hit (fix_hit[i])
    );
  end

  logic [1:0] cmb_hit;

  brk_route #(.PC_W(PC_W), .DA_W(DA_W)) u_route (
    .ctrl    (ctrl),
    .cmb_val (cmb_val),
    .cmb_en  (cmb_en),
    .pc      (pc_i),
    .retire  (retire_i),
    .daddr   (daddr_i),
    .drd     (drd_i),
    .dwr     (dwr_i),
    .cmb_hit (cmb_hit)
  );

  logic [NSRC-1:0] hit_d, hit_q;
  logic [NSRC-1:0] stat_d, stat_q;
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    hit_d = {retire_i && step_en,
             retire_i && flow_chg_i && flow_en,
             cmb_hit,
             fix_hit};
    clr_mask = (cfg_we_i && cfg_addr_i == AW'(CLR_ADDR)) ? cfg_wdata_i[NSRC-1:0] : '0;
    stat_d   = (stat_q & ~clr_mask) | hit_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hit_q  <= '0;
      stat_q <= '0;
    end else begin
      hit_q  <= hit_d;
      stat_q <= stat_d;
    end
  end

  assign brk_o     = |hit_q;
  assign brk_src_o = stat_q;

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int AW   = 3,
  parameter int NSRC = 6,
  parameter int NFIX = 2
) (
  input logic            clk,
  input logic            rst_q,
  input logic            retire_i,
  input logic            flow_chg_i,
  input logic            drd_i,
  input logic            dwr_i,
  input logic            cfg_we_i,
  input logic [AW-1:0]   cfg_addr_i,
  input logic [NSRC-1:0] cfg_lo,
  input logic            step_en,
  input logic            flow_en,
  input logic            brk_o,
  input logic [NSRC-1:0] brk_src_o
);

  logic [NSRC-1:0] clr_seen;
  assign clr_seen = (cfg_we_i && cfg_addr_i == AW'(NFIX + 3)) ? cfg_lo : '0;

  // R10: a retirement with single-step on pulses and sets the step bit
  a_r10_step_break: assert property (@(posedge clk) disable iff (!rst_q)
    (retire_i && step_en) |=> (brk_o && brk_src_o[NSRC-1]));

  // R9: a retired flow change with flow-break on sets the flow bit
  a_r9_flow_break: assert property (@(posedge clk) disable iff (!rst_q)
    (retire_i && flow_chg_i && flow_en) |=> (brk_o && brk_src_o[NSRC-2]));

  // R11: no event, no pulse in the next cycle
  a_r11_no_event_no_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    (!retire_i && !drd_i && !dwr_i) |=> !brk_o);

  // R11: status bits survive unless a one is written to them
  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> ((($past(brk_src_o) & ~$past(clr_seen)) & ~brk_src_o) == '0));

  // R11: every pulse is reflected in the status vector
  a_r11_pulse_has_source: assert property (@(posedge clk) disable iff (!rst_q)
    brk_o |-> (brk_src_o != '0));

endmodule

bind brk_unit brk_unit_chk #(.AW(AW), .NSRC(NSRC), .NFIX(NFIX)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .retire_i   (retire_i),
  .flow_chg_i (flow_chg_i),
  .drd_i      (drd_i),
  .dwr_i      (dwr_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_lo     (cfg_wdata_i[NSRC-1:0]),
  .step_en    (step_en),
  .flow_en    (flow_en),
  .brk_o      (brk_o),
  .brk_src_o  (brk_src_o)
);

// File: tb/sim_brk_unit.sv
module sim_brk_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] pc;
  logic        retire, flow;
  logic [15:0] daddr;
  logic        drd, dwr;
  logic        we;
  logic [2:0]  addr;
  logic [17:0] wdata;
  logic        brk;
  logic [5:0]  src;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  brk_unit u0 (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .retire_i(retire), .flow_chg_i(flow),
    .daddr_i(daddr), .drd_i(drd), .dwr_i(dwr), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .brk_o(brk), .brk_src_o(src)
  );

  // {pc, retire, flow, daddr, rd, wr, exp pulse, exp status}
  localparam logic [43:0] VEC [11] = '{
    {17'h00100, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'b000001},
    {17'h1FFFF, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'b000010},
    {17'h00200, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'b000100},
    {17'h00100, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'b000000},
    {17'h00000, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b1, 1'b1, 6'b001000},
    {17'h00000, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0, 6'b000000},
    {17'h00101, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'b000000},
    {17'h00300, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1, 6'b010000},
    {17'h00300, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 6'b000000},
    {17'h00100, 1'b1, 1'b1, 16'h1234, 1'b0, 1'b1, 1'b1, 6'b011001},
    {17'h00000, 1'b0, 1'b0, 16'h1235, 1'b0, 1'b1, 1'b0, 6'b000000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [17:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ev(input logic [16:0] p, input logic r, input logic f,
                    input logic [15:0] da, input logic rd, input logic wr,
                    input logic ep, input logic [5:0] es, input logic do_clr,
                    input string req);
    @(negedge clk);
    pc = p; retire = r; flow = f; daddr = da; drd = rd; dwr = wr;
    @(negedge clk);
    retire = 1'b0; flow = 1'b0; drd = 1'b0; dwr = 1'b0;
    chk({req, " pulse"}, 32'(brk), 32'(ep));
    chk({req, " status"}, 32'(src), 32'(es));
    @(negedge clk);
    chk({req, " pulse width"}, 32'(brk), 32'd0);
    if (do_clr) wr_cfg(3'd5, 18'h0003F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pc = '0; retire = 0; flow = 0; daddr = '0; drd = 0; dwr = 0;
    we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset pulse", 32'(brk), 32'd0);
    chk("R1 reset status", 32'(src), 32'd0);
    ev(17'h00100, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R1 inert after reset");

    // table configuration: mode 1, slot1 writes only, flow on (R2 R3 R7 R9)
    wr_cfg(3'd0, 18'h20100);
    wr_cfg(3'd1, 18'h3FFFF);
    wr_cfg(3'd2, 18'h20200);
    wr_cfg(3'd3, 18'h21234);
    wr_cfg(3'd4, 18'h000C1);
    for (int i = 0; i < 11; i++) begin
      ev(VEC[i][43:27], VEC[i][26], VEC[i][25], VEC[i][24:9], VEC[i][8], VEC[i][7],
         VEC[i][6], VEC[i][5:0], 1, $sformatf("R2/R3/R7/R9 vector %0d", i));
    end

    // R10 single step
    wr_cfg(3'd4, 18'h001C1);
    ev(17'h00555, 1, 0, 16'h0, 0, 0, 1, 6'b100000, 1, "R10 step");
    ev(17'h00100, 1, 0, 16'h0, 0, 0, 1, 6'b100001, 1, "R10 step with fix0");
    ev(17'h00555, 0, 0, 16'h0, 0, 0, 0, 6'b000000, 1, "R10 no retire");
    wr_cfg(3'd4, 18'h000C1);

    // R8 disabled comparator
    wr_cfg(3'd0, 18'h00100);
    ev(17'h00100, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R8 disabled fix0");

    // R3 mode 0: both combined slots on program addresses
    wr_cfg(3'd3, 18'h20ABC);
    wr_cfg(3'd4, 18'h00000);
    ev(17'h00ABC, 1, 0, 16'h0, 0, 0, 1, 6'b001000, 1, "R3 mode0 slot1 program");
    ev(17'h0, 0, 0, 16'h0ABC, 1, 1, 0, 6'b0, 1, "R3 mode0 ignores data");

    // R3/R7 mode 2: both data, slot0 reads, slot1 either
    wr_cfg(3'd2, 18'h24000);
    wr_cfg(3'd4, 18'h0006A);
    ev(17'h0, 0, 0, 16'h4000, 1, 0, 1, 6'b000100, 1, "R3 mode2 slot0 read");
    ev(17'h0, 0, 0, 16'h4000, 0, 1, 0, 6'b0, 1, "R7 read-only qual on write");
    ev(17'h0, 0, 0, 16'h0ABC, 0, 1, 1, 6'b001000, 1, "R7 either qual on write");
    ev(17'h04000, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R3 mode2 ignores pc");
    wr_cfg(3'd4, 18'h00062);
    ev(17'h0, 0, 0, 16'h4000, 1, 1, 0, 6'b0, 1, "R7 qual none");

    // R4 program range
    wr_cfg(3'd2, 18'h21000);
    wr_cfg(3'd3, 18'h1FF00);
    wr_cfg(3'd4, 18'h00003);
    ev(17'h010AB, 1, 0, 16'h0, 0, 0, 1, 6'b000100, 1, "R4 inside range");
    ev(17'h011AB, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R4 outside range");
    ev(17'h1FF00, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R4 slot1 idle in range");
    ev(17'h1FFFF, 1, 0, 16'h0, 0, 0, 1, 6'b000010, 1, "R6 fixed active in range");

    // R5 data range
    wr_cfg(3'd2, 18'h28000);
    wr_cfg(3'd3, 18'h0F000);
    wr_cfg(3'd4, 18'h0001C);
    ev(17'h0, 0, 0, 16'h8FFF, 0, 1, 1, 6'b000100, 1, "R5 inside data range");
    ev(17'h0, 0, 0, 16'h9000, 1, 0, 0, 6'b0, 1, "R5 outside data range");
    ev(17'h08000, 1, 0, 16'h0, 0, 0, 0, 6'b0, 1, "R5 ignores pc");

    // R6 undefined mode
    wr_cfg(3'd2, 18'h21000);
    wr_cfg(3'd3, 18'h21000);
    wr_cfg(3'd4, 18'h00005);
    ev(17'h01000, 1, 0, 16'h1000, 1, 1, 0, 6'b0, 1, "R6 mode5 combined off");
    ev(17'h1FFFF, 1, 0, 16'h0, 0, 0, 1, 6'b000010, 1, "R6 mode5 fixed on");

    // R11 sticky status and clear
    wr_cfg(3'd4, 18'h00000);
    wr_cfg(3'd0, 18'h20100);
    ev(17'h1FFFF, 1, 0, 16'h0, 0, 0, 1, 6'b000010, 0, "R11 first source");
    ev(17'h00100, 1, 0, 16'h0, 0, 0, 1, 6'b000011, 0, "R11 accumulate");
    wr_cfg(3'd5, 18'h00001);
    chk("R11 partial clear", 32'(src), 32'h2);
    chk("R11 idle no pulse", 32'(brk), 32'd0);
    // set wins over clear in the same cycle
    @(negedge clk);
    pc = 17'h00100; retire = 1'b1; we = 1'b1; addr = 3'd5; wdata = 18'h00001;
    @(negedge clk);
    retire = 1'b0; we = 1'b0;
    chk("R11 set beats clear", 32'(src), 32'h3);
    chk("R11 pulse on set", 32'(brk), 32'd1);
    wr_cfg(3'd5, 18'h0003F);
    chk("R11 full clear", 32'(src), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule